// File: doc/BRIEF.md
# Serial Channel-Value Loader

This block is a three-wire serial slave that receives 16-bit command words and stores a 10-bit value for each of several output channels, together with a flag that picks the refresh clock source. A frame is bounded by an active-low select. While the select is low, each rising edge of the serial clock moves one data bit into a 16-bit shift register, most significant bit first. When the select returns high, the word now held in the shift register is decoded and committed.

Each word has four fields. The top bit is reserved and must be zero. The next bit picks the refresh clock: 0 for internal, 1 for external. Below that is a 4-bit channel number, and the lowest bits hold the 10-bit value. The shift register's top bit is copied to a serial output on falling serial-clock edges. Several devices can therefore be chained on one select line and one clock. Each device keeps the last 16 bits that passed through it, and all devices commit together when the shared select rises.

The serial pins are asynchronous to the system clock. They are synchronised and edge-detected inside the block, so the serial clock must be several times slower than the system clock.

Top module: `serial_chan_loader`

## Requirements
- R1: After a synchronous reset, every channel value is 0, the clock-source flag is 0 (internal) and the serial output is 0.
- R2: While the select is low, each rising serial-clock edge shifts the data input into the 16-bit register, first bit at position 15. A frame of exactly 16 clocks commits bits 9..0 to the addressed channel when the select rises.
- R3: Bits 13..10 are an unsigned channel number, where 0 is the first channel and NCH-1 is the last.
- R4: On a commit with bit 15 clear, the clock-source flag takes bit 14 (1 selects the external clock).
- R5: A word with bit 15 set changes neither any channel value nor the clock-source flag.
- R6: A word with bit 15 clear and a channel number of NCH or above changes no channel value but still updates the clock-source flag.
- R7: Serial-clock and data activity while the select is high has no effect: the outputs are unchanged, and the next 16-clock frame commits exactly its own word.
- R8: The serial output changes only on falling serial-clock edges while the select is low. The bit shifted in on rising edge k appears on the serial output at falling edge k+15.
- R9: In a chain of two devices that share the select and clock, with 32 bits sent, the first 16 bits are committed by the second device and the last 16 bits by the first, both on the same select rise.
- R10: A frame with fewer than 16 clocks commits the current shift-register contents: the earlier bits moved up by the number of new bits, with the new bits at the bottom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low frame select, asynchronous |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output for chaining |
| chan_val_o | output | NCH*DATA_W | Channel values packed together, with channel c at bits [c*DATA_W +: DATA_W] |
| ext_clk_sel_o | output | 1 | Clock-source flag, 1 = external |

## Verification
The bench builds the block with NCH = 10 and two synchroniser stages, and drives the serial clock at 16 system clocks per period. With ten channels in a 4-bit address field, the out-of-range numbers 10 to 15 can be tested. With two synchroniser stages, the reference model can predict every output on every cycle. A second instance is chained from the first instance's serial output, so the 32-bit frame and the shared commit are checked at the ports. The short-frame case is checked after a full frame, so the mixing of old and new bits can be seen.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 10;
  localparam int WORD_W = 2 + ADDR_W + DATA_W;

  typedef struct packed {
    logic                rsv;
    logic                ext;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
  } cmd_word_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
      q_d <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      q_d <= stg[STAGES-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter
  import serial_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              out_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      sdo_o  <= 1'b0;
    end else begin
      if (shift_i) word_o <= {word_o[WORD_W-2:0], sdi_i};
      if (out_i)   sdo_o  <= word_o[WORD_W-1];
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(word_o));

  // R8
  sdo_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    !out_i |=> $stable(sdo_o));
endmodule

// File: rtl/chan_regfile.sv
module chan_regfile
  import serial_chan_pkg::*;
#(
  parameter int NCH = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit_i,
  input  cmd_word_t             word_i,
  output logic [NCH*DATA_W-1:0] chan_o,
  output logic                  ext_sel_o
);
  logic accept;
  assign accept = commit_i && !word_i.rsv;

  always_ff @(posedge clk) begin
    if (rst)         ext_sel_o <= 1'b0;
    else if (accept) ext_sel_o <= word_i.ext;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        chan_o[g*DATA_W +: DATA_W] <= '0;
      else if (accept && (word_i.addr == ADDR_W'(g)))
        chan_o[g*DATA_W +: DATA_W] <= word_i.data;
    end
  end

  // R5
  rsv_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && word_i.rsv) |=> ($stable(chan_o) && $stable(ext_sel_o)));

  // R6
  oob_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !word_i.rsv && (int'(word_i.addr) >= NCH)) |=> $stable(chan_o));

  // R4
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !word_i.rsv) |=> (ext_sel_o == $past(word_i.ext)));

  // R2
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(chan_o) && $stable(ext_sel_o)));
endmodule

// File: rtl/serial_chan_loader.sv
module serial_chan_loader
  import serial_chan_pkg::*;
#(
  parameter int NCH  = 10,
  parameter int SYNC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_i,
  input  logic                  cs_n_i,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  output logic [NCH*DATA_W-1:0] chan_val_o,
  output logic                  ext_clk_sel_o
);
  localparam int B_SCLK = 0;
  localparam int B_CSN  = 1;
  localparam int B_SDI  = 2;

  logic [2:0] pin_q, pin_qd;
  logic       sel, sclk_rise, sclk_fall, frame_end;
  logic [WORD_W-1:0] word;

  pin_sync #(.W(3), .STAGES(SYNC), .INIT(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sdi_i, cs_n_i, sclk_i}),
    .q   (pin_q),
    .q_d (pin_qd)
  );

  assign sel       = !pin_q[B_CSN];
  assign sclk_rise =  pin_q[B_SCLK] && !pin_qd[B_SCLK];
  assign sclk_fall = !pin_q[B_SCLK] &&  pin_qd[B_SCLK];
  assign frame_end =  pin_q[B_CSN]  && !pin_qd[B_CSN];

  cmd_shifter u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (sel && sclk_rise),
    .out_i   (sel && sclk_fall),
    .sdi_i   (pin_q[B_SDI]),
    .word_o  (word),
    .sdo_o   (sdo_o)
  );

  chan_regfile #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (frame_end),
    .word_i    (cmd_word_t'(word)),
    .chan_o    (chan_val_o),
    .ext_sel_o (ext_clk_sel_o)
  );
endmodule

// File: tb/serial_chan_loader_tb.sv
`timescale 1ns/1ps
module serial_chan_loader_tb;
  import serial_chan_pkg::*;
  localparam int NCH  = 10;
  localparam int SYNC = 2;
  localparam int HALF = 8;

  logic clk = 0, rst = 1, sclk = 0, csn = 1, sdi = 0;
  logic sdo1, sdo2, ext1, ext2;
  logic [NCH*DATA_W-1:0] ch1, ch2;

  always #2 clk = ~clk;

  serial_chan_loader #(.NCH(NCH), .SYNC(SYNC)) u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(csn), .sdi_i(sdi),
    .sdo_o(sdo1), .chan_val_o(ch1), .ext_clk_sel_o(ext1));

  serial_chan_loader #(.NCH(NCH), .SYNC(SYNC)) u_dut2 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(csn), .sdi_i(sdo1),
    .sdo_o(sdo2), .chan_val_o(ch2), .ext_clk_sel_o(ext2));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int chan_of(logic [NCH*DATA_W-1:0] v, int c);
    return int'(v[c*DATA_W +: DATA_W]);
  endfunction

  // behavioural reference for u_dut
  logic [15:0] m_sh;
  int          m_ch [NCH];
  logic        m_ext, m_sdo;
  logic [2:0]  hist [SYNC+2];

  always @(posedge clk) begin
    if (rst) begin
      m_sh = 0; m_ext = 0; m_sdo = 0;
      for (int c = 0; c < NCH; c++) m_ch[c] = 0;
      for (int k = 0; k < SYNC+2; k++) hist[k] = 3'b010;
    end else begin
      logic [2:0] cur, old;
      for (int k = SYNC+1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = {sdi, csn, sclk};
      cur = hist[SYNC];
      old = hist[SYNC+1];
      if (!cur[1] && cur[0] && !old[0]) m_sh = {m_sh[14:0], cur[2]};
      else if (!cur[1] && !cur[0] && old[0]) m_sdo = m_sh[15];
      if (cur[1] && !old[1] && !m_sh[15]) begin
        m_ext = m_sh[14];
        if (int'(m_sh[13:10]) < NCH) m_ch[m_sh[13:10]] = int'(m_sh[9:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R8 sdo per-cycle", sdo1, m_sdo);
      check("R4 mode per-cycle", ext1, m_ext);
      for (int c = 0; c < NCH; c++) check("R2 chan per-cycle", chan_of(ch1, c), m_ch[c]);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    csn = 0;
    wait_n(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_n(HALF);
      sclk = 1;
      wait_n(HALF);
      sclk = 0;
    end
    wait_n(HALF);
    csn = 1;
    wait_n(HALF);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    wait_n(4);
    rst = 0;
    wait_n(3);
    // R1 reset state
    for (int c = 0; c < NCH; c++) check("R1 chan reset", chan_of(ch1, c), 0);
    check("R1 mode reset", ext1, 0);
    check("R1 sdo reset", sdo1, 0);

    // R2 R3: channel 3 = 0x155, internal clock
    send(32'h0D55, 16);
    check("R2 R3 chan3 write", chan_of(ch1, 3), 'h155);
    check("R4 mode internal", ext1, 0);
    check("R8 sdo shows word msb", sdo1, 0);

    // R3 R4: last channel 9 = 1023, external clock
    send(32'h67FF, 16);
    check("R3 chan9 write", chan_of(ch1, 9), 'h3FF);
    check("R4 mode external", ext1, 1);

    // R5: reserved bit set, discarded
    send(32'h8C01, 16);
    check("R5 chan3 kept", chan_of(ch1, 3), 'h155);
    check("R5 mode kept", ext1, 1);
    check("R8 sdo shows reserved msb", sdo1, 1);

    // R6: channel 12, mode back to internal
    send(32'h32AA, 16);
    check("R6 mode updated", ext1, 0);
    check("R6 chan0 untouched", chan_of(ch1, 0), 0);
    check("R6 chan3 untouched", chan_of(ch1, 3), 'h155);
    check("R6 chan9 untouched", chan_of(ch1, 9), 'h3FF);

    // R7: activity with select high
    for (int i = 0; i < 20; i++) begin
      sdi = i[0] ^ i[2];
      wait_n(HALF); sclk = 1;
      wait_n(HALF); sclk = 0;
    end
    wait_n(HALF);
    check("R7 sdo idle", sdo1, 0);
    check("R7 chan3 idle", chan_of(ch1, 3), 'h155);
    check("R7 mode idle", ext1, 0);
    send(32'h0123, 16);
    check("R7 clean frame after idle", chan_of(ch1, 0), 'h123);

    // R10: 4-bit frame leaves 0x1234 in the register -> channel 4 = 0x234
    send(32'h4, 4);
    check("R10 short frame chan4", chan_of(ch1, 4), 'h234);
    check("R10 short frame chan0 kept", chan_of(ch1, 0), 'h123);

    // R9: chained pair, first word to second device
    send({16'h06AA, 16'h08F0}, 32);
    check("R9 near device chan2", chan_of(ch1, 2), 'h0F0);
    check("R9 far device chan1", chan_of(ch2, 1), 'h2AA);
    check("R9 near device mode", ext1, 0);
    check("R9 far device mode", ext2, 0);

    wait_n(4);
    finish_run();
  end
endmodule